// File: doc/BRIEF.md
# FIFO-Gated SPI Master Controller

This block is an SPI master that moves 32-bit words from a transmit FIFO out on MOSI while it collects the same number of bits from MISO into a receive FIFO. The serial clock idles low. Data changes on the falling edge and is captured on the rising edge. Each frame begins half a bit period before the first rising edge, so MOSI already holds the most significant bit when that edge comes.

The serial clock runs only when three conditions hold: the transmitter is enabled, the transmit FIFO holds a word, and, when reception is enabled, the receive FIFO has room. While these conditions stay true, frames follow one another with a programmable gap between them. When any condition fails, the controller halts at the next frame boundary. A programmable lead time separates slave-select assertion from the first clock edge. Software should clear both enables before it changes the divider or the delays, and set them again afterwards.

Top module: `spi_fifo_master`

## Requirements
- R1: Each frame shifts out 32 bits on MOSI, most significant bit first. MOSI never changes while SCK is high. The word sent is the oldest word in the transmit FIFO.
- R2: SCK is low whenever the active-low slave select `ssN` is high, and it is low after reset.
- R3: A frame starts (`ssN` falls) only when `txEnable` is 1, the transmit FIFO is not empty, and either `rxEnable` is 0 or the receive FIFO is not full.
- R4: Frames run back to back while the start condition of R3 holds. When the condition fails, the controller finishes the current frame and then stays idle with `ssN` high, even if words remain in the transmit FIFO.
- R5: The first rising SCK edge of a frame comes exactly `leadDelay + halfDiv + 2` clock cycles after `ssN` falls. A zero setting gives the shortest delay.
- R6: `ssN` stays high for at least `gapDelay + 2` clock cycles between frames. When the next frame is ready at the end of the current one, the gap is exactly `gapDelay + 2` cycles.
- R7: MISO is captured on each rising SCK edge, most significant bit first. When `rxEnable` is 1, the 32-bit word is pushed into the receive FIFO at the end of the frame, and `rxData` shows the oldest stored word.
- R8: When `rxEnable` is 0, received words are discarded. The receive FIFO stays unchanged and does not block transfers.
- R9: Clearing `txEnable` during a frame lets that frame complete. No further frame starts until `txEnable` is set again.
- R10: The status outputs are `busy`, `txEmpty`, `rxFull` and `rxNotEmpty`. A push into a full FIFO and a pop from an empty FIFO are ignored. After reset, both FIFOs are empty and `busy` is 0.
- R11: While SCK runs, its high phase and its low phase each last `halfDiv + 1` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Allows frames to start |
| rxEnable | input | 1 | Stores received words in the receive FIFO |
| halfDiv | input | 8 | SCK half period minus one, in clock cycles |
| leadDelay | input | 8 | Select-to-clock lead setting |
| gapDelay | input | 8 | Inter-frame gap setting |
| txPush | input | 1 | Writes txData into the transmit FIFO |
| txData | input | 32 | Word to transmit |
| txEmpty | output | 1 | Transmit FIFO is empty |
| rxPop | input | 1 | Removes the oldest received word |
| rxData | output | 32 | Oldest received word |
| rxNotEmpty | output | 1 | Receive FIFO holds at least one word |
| rxFull | output | 1 | Receive FIFO is full |
| busy | output | 1 | A frame, lead or gap is in progress |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Slave select, active low |

## Verification
Some properties are checked by assertions on every cycle: SCK stays low outside a frame, MOSI holds steady while SCK is high, every start of a frame is backed by the enable and FIFO conditions, each receive push lines up with the end of a frame, and neither FIFO count goes beyond its depth. Other behaviour only the bench scenarios can show. These include the exact cycle counts of the lead time, the gap and the SCK phases, the bit order of the words on both data lines, the halt at a frame boundary when the receive FIFO fills or the transmitter is disabled, and the words that are discarded while reception is off.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP} spimState_e;

  // strobes from the control FSM to the shift datapath
  typedef struct packed {
    logic load;    // take a new word from the transmit FIFO
    logic sample;  // capture MISO (rising SCK)
    logic shift;   // advance MOSI (falling SCK)
  } spimStrobe_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] wrData,
  input  logic             pop,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_full_push_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
  assert_empty_pop_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strb,
  input  logic [DATA_W-1:0] txWord,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.load)       txShift <= txWord;
      else if (strb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.sample)     rxShift <= {rxShift[DATA_W-2:0], miso};
    end
  end

  assign mosi   = txShift[DATA_W-1];
  assign rxWord = rxShift;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  parameter int DLY_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [DLY_W-1:0] leadDelay,
  input  logic [DLY_W-1:0] gapDelay,
  input  logic             txEmpty,
  input  logic             rxFull,
  output spimStrobe_t      strb,
  output logic             txPop,
  output logic             rxPush,
  output logic             sck,
  output logic             ssN,
  output logic             busy
);
  localparam int CNT_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;
  localparam int BIT_W = $clog2(DATA_W + 1);

  spimState_e state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [BIT_W-1:0] bitCnt, bitN;
  logic sckQ, sckN, ssQ, ssNext, startOk;

  assign startOk = txEnable && !txEmpty && !(rxEnable && rxFull);

  always_comb begin
    stateN = state;
    cntN   = cnt;
    bitN   = bitCnt;
    sckN   = sckQ;
    ssNext = ssQ;
    strb   = '0;
    txPop  = 1'b0;
    rxPush = 1'b0;
    case (state)
      ST_IDLE: if (startOk) begin
        txPop     = 1'b1;
        strb.load = 1'b1;
        ssNext    = 1'b0;
        cntN      = CNT_W'(leadDelay);
        stateN    = ST_LEAD;
      end
      ST_LEAD: if (cnt == '0) begin
        stateN = ST_SHIFT;
        cntN   = CNT_W'(halfDiv);
        bitN   = '0;
      end else cntN = cnt - CNT_W'(1);
      ST_SHIFT: if (cnt != '0) cntN = cnt - CNT_W'(1);
      else if (!sckQ) begin
        sckN        = 1'b1;
        strb.sample = 1'b1;
        bitN        = bitCnt + BIT_W'(1);
        cntN        = CNT_W'(halfDiv);
      end else begin
        sckN = 1'b0;
        cntN = CNT_W'(halfDiv);
        if (bitCnt == BIT_W'(DATA_W)) begin
          rxPush = rxEnable;
          ssNext = 1'b1;
          cntN   = CNT_W'(gapDelay);
          stateN = ST_GAP;
        end else strb.shift = 1'b1;
      end
      ST_GAP: if (cnt == '0) stateN = ST_IDLE;
      else cntN = cnt - CNT_W'(1);
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      sckQ   <= 1'b0;
      ssQ    <= 1'b1;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      bitCnt <= bitN;
      sckQ   <= sckN;
      ssQ    <= ssNext;
    end
  end

  assign sck  = sckQ;
  assign ssN  = ssQ;
  assign busy = (state != ST_IDLE);

  assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !sck);
  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ssN) |-> $past(txEnable && !txEmpty && !(rxEnable && rxFull)));
  assert_push_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |=> ($rose(ssN) && !sck));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spim_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int DIV_W   = 8,
  parameter int DLY_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [DLY_W-1:0]  leadDelay,
  input  logic [DLY_W-1:0]  gapDelay,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txData,
  output logic              txEmpty,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNotEmpty,
  output logic              rxFull,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);
  spimStrobe_t strb;
  logic txPop, rxPush, txFull, rxEmpty;
  logic [DATA_W-1:0] txHead, rxWord;

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(txPush), .wrData(txData), .pop(txPop),
    .rdData(txHead), .full(txFull), .empty(txEmpty));

  spim_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .wrData(rxWord), .pop(rxPop),
    .rdData(rxData), .full(rxFull), .empty(rxEmpty));

  spim_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .halfDiv(halfDiv), .leadDelay(leadDelay), .gapDelay(gapDelay),
    .txEmpty(txEmpty), .rxFull(rxFull), .strb(strb), .txPop(txPop),
    .rxPush(rxPush), .sck(sck), .ssN(ssN), .busy(busy));

  spim_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txWord(txHead), .miso(miso),
    .mosi(mosi), .rxWord(rxWord));

  assign rxNotEmpty = !rxEmpty;

  assert_mosi_steady_R1: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));
  assert_tx_full_push_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull && !txPop) |=> !txEmpty);
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic txEnable = 1'b0, rxEnable = 1'b0;
  logic [7:0] halfDiv = 8'd1, leadDelay = 8'd0, gapDelay = 8'd0;
  logic txPush = 1'b0, rxPop = 1'b0, miso = 1'b0;
  logic [31:0] txData = '0;
  logic txEmpty, rxNotEmpty, rxFull, busy, sck, mosi, ssN;
  logic [31:0] rxData;

  always #2 clk = ~clk;

  spi_fifo_master u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rxEnable(rxEnable),
    .halfDiv(halfDiv), .leadDelay(leadDelay), .gapDelay(gapDelay),
    .txPush(txPush), .txData(txData), .txEmpty(txEmpty), .rxPop(rxPop),
    .rxData(rxData), .rxNotEmpty(rxNotEmpty), .rxFull(rxFull), .busy(busy),
    .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] txQ[$], rxQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slvWord(input int k);
    return 32'h8000_0001 ^ (32'(k) * 32'h1357_9BDF);
  endfunction

  // monitor and slave model, sampled on the falling clock edge
  int cyc = 0, fallCyc = 0, riseSsCyc = -1, lastRise = 0, lastFall = 0;
  int bitsSeen = 0, lastGap = 0, frames = 0, slvIdx = 0;
  logic prevSs = 1'b1, prevSck = 1'b0;
  logic [31:0] mosiWord = '0, slvShift = '0, curSlv = '0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (prevSs && !ssN) begin
        if (riseSsCyc >= 0) begin
          lastGap = cyc - riseSsCyc;
          chk(lastGap >= gapDelay + 2, "R6", "gap length", lastGap, gapDelay + 2);
        end
        fallCyc = cyc; bitsSeen = 0;
        slvShift = slvWord(slvIdx); curSlv = slvShift; slvIdx++;
        miso = slvShift[31];
      end
      if (!prevSck && sck) begin
        if (bitsSeen == 0)
          chk(cyc - fallCyc == leadDelay + halfDiv + 2, "R5", "lead time",
              cyc - fallCyc, leadDelay + halfDiv + 2);
        else
          chk(cyc - lastFall == halfDiv + 1, "R11", "sck low width",
              cyc - lastFall, halfDiv + 1);
        mosiWord = {mosiWord[30:0], mosi};
        bitsSeen++; lastRise = cyc;
      end
      if (prevSck && !sck) begin
        chk(cyc - lastRise == halfDiv + 1, "R11", "sck high width",
            cyc - lastRise, halfDiv + 1);
        lastFall = cyc;
        slvShift = slvShift << 1;
        miso = slvShift[31];
      end
      if (!prevSs && ssN) begin
        chk(bitsSeen == 32, "R1", "bits per frame", bitsSeen, 32);
        if (txQ.size() > 0) begin
          logic [31:0] e;
          e = txQ.pop_front();
          chk(mosiWord == e, "R1", "mosi word", mosiWord, e);
        end else chk(0, "R3", "frame without queued word", mosiWord, 0);
        if (rxEnable) rxQ.push_back(curSlv);
        frames++; riseSsCyc = cyc;
      end
      prevSs = ssN; prevSck = sck;
    end
  end

  task automatic pushTx(input logic [31:0] w, input bit accept);
    @(negedge clk); txData = w; txPush = 1'b1;
    if (accept) txQ.push_back(w);
    @(negedge clk); txPush = 1'b0;
  endtask

  task automatic popRx();
    @(negedge clk);
    chk(rxNotEmpty == 1'b1, "R10", "rxNotEmpty before pop", rxNotEmpty, 1);
    if (rxQ.size() > 0) begin
      logic [31:0] e;
      e = rxQ.pop_front();
      chk(rxData == e, "R7", "received word", rxData, e);
    end
    rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask

  task automatic waitFrames(input int target);
    for (int g = 0; g < 40000 && frames < target; g++) @(negedge clk);
    for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(ssN == 1'b1 && sck == 1'b0, "R2", "idle lines", {ssN, sck}, 2'b10);
    chk(busy == 1'b0 && txEmpty == 1'b1, "R10", "reset busy/txEmpty", {busy, txEmpty}, 2'b01);
    chk(rxNotEmpty == 1'b0 && rxFull == 1'b0, "R10", "reset rx flags", {rxNotEmpty, rxFull}, 0);
    // pop from empty receive FIFO is ignored
    @(negedge clk); rxPop = 1'b1; @(negedge clk); rxPop = 1'b0; @(negedge clk);
    chk(rxNotEmpty == 1'b0 && rxFull == 1'b0, "R10", "pop empty ignored", rxNotEmpty, 0);

    // S1: gated start, back-to-back frames
    halfDiv = 8'd1; leadDelay = 8'd3; gapDelay = 8'd2; rxEnable = 1'b1;
    pushTx(32'hDEAD_BEEF, 1); pushTx(32'h0000_0000, 1); pushTx(32'hFFFF_FFFF, 1);
    repeat (30) @(negedge clk);
    chk(ssN == 1'b1 && busy == 1'b0, "R3", "no start while tx disabled", ssN, 1);
    txEnable = 1'b1;
    waitFrames(3);
    chk(frames == 3, "R4", "back-to-back frame count", frames, 3);
    chk(lastGap == gapDelay + 2, "R6", "exact gap", lastGap, gapDelay + 2);
    chk(txEmpty == 1'b1 && busy == 1'b0, "R4", "idle after drain", {txEmpty, busy}, 2'b10);

    // S2: receive FIFO fills, halt at frame boundary; push into full tx ignored
    txEnable = 1'b0;
    pushTx(32'h8000_0001, 1); pushTx(32'h1234_5678, 1);
    pushTx(32'hA5A5_5A5A, 1); pushTx(32'h0F0F_F0F0, 1);
    pushTx(32'h7777_7777, 0);
    txEnable = 1'b1;
    repeat (600) @(negedge clk);
    chk(frames == 4, "R4", "halt when rx full", frames, 4);
    chk(rxFull == 1'b1 && txEmpty == 1'b0 && ssN == 1'b1, "R4", "stopped with tx data",
        {rxFull, txEmpty, ssN}, 3'b101);
    for (int i = 0; i < 3; i++) begin
      popRx();
      waitFrames(5 + i);
    end
    repeat (300) @(negedge clk);
    chk(frames == 7, "R10", "extra push to full tx ignored", frames, 7);
    chk(txEmpty == 1'b1, "R10", "tx drained", txEmpty, 1);
    for (int i = 0; i < 4; i++) popRx();
    @(negedge clk);
    chk(rxNotEmpty == 1'b0, "R7", "rx drained", rxNotEmpty, 0);

    // S3: reconfigure while disabled, then disable tx mid-frame
    txEnable = 1'b0; rxEnable = 1'b0;
    halfDiv = 8'd0; leadDelay = 8'd0; gapDelay = 8'd0;
    rxEnable = 1'b1;
    pushTx(32'hC3C3_3C3C, 1); pushTx(32'h0123_4567, 1);
    f0 = frames;
    txEnable = 1'b1;
    for (int g = 0; g < 2000 && !(bitsSeen >= 5 && !ssN); g++) @(negedge clk);
    txEnable = 1'b0;
    repeat (300) @(negedge clk);
    chk(frames == f0 + 1, "R9", "frame completes after disable", frames, f0 + 1);
    chk(txEmpty == 1'b0 && busy == 1'b0, "R9", "no new frame", {txEmpty, busy}, 2'b00);
    txEnable = 1'b1;
    waitFrames(f0 + 2);
    popRx(); popRx();

    // S4: reception disabled discards words
    rxEnable = 1'b0; halfDiv = 8'd2; leadDelay = 8'd1; gapDelay = 8'd5;
    f0 = frames;
    pushTx(32'h1111_2222, 1); pushTx(32'h3333_4444, 1); pushTx(32'hFEDC_BA98, 1);
    waitFrames(f0 + 3);
    chk(frames == f0 + 3, "R8", "frames run with rx disabled", frames, f0 + 3);
    chk(rxNotEmpty == 1'b0, "R8", "words discarded", rxNotEmpty, 0);
    chk(lastGap == gapDelay + 2, "R6", "exact gap, second setting", lastGap, gapDelay + 2);
    chk(ssN == 1'b1 && sck == 1'b0, "R2", "idle lines at end", {ssN, sck}, 2'b10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule